// File: doc/BRIEF.md
# Dual-Register Waveform Synthesis Core

This block is the digital heart of a direct digital synthesizer. A wide phase accumulator runs on the master clock. On every cycle it adds one of two stored frequency tuning words. The top bits of the accumulator are offset by one of two stored phase words to form a lookup phase. Two select inputs pick the words, so frequency or phase modulation reduces to toggling a pin once both words are loaded.

The lookup phase produces a sample word for a downstream converter. The sample is either a sine amplitude read from a quarter-wave table built at elaboration, or a linear up/down triangle ramp when the table is bypassed. A separate one-bit clock output carries the phase MSB as a square wave, or that square wave divided by two.

A sleep input freezes the sample word while the accumulator and the clock output keep running. Registers are loaded through a parallel write port with a two-bit register select.

Top module: `dds_wave_core`

## Requirements
- R1: The 28-bit accumulator adds the selected frequency word on every clock that is not in reset, wrapping modulo 2^28.
- R2: `freq_sel` = 0 selects frequency word 0 and `freq_sel` = 1 selects frequency word 1. The selection applies from the next clock edge.
- R3: The lookup phase is (accumulator bits 27:16 + selected 12-bit phase word) mod 4096. `phase_sel` = 0 selects phase word 0 and `phase_sel` = 1 selects phase word 1.
- R4: With `tbl_bypass` = 0, the sample is 512 + round(511 · sin(2π·p/4096)) for lookup phase p, to within one LSB. It always lies in 1..1023.
- R5: With `tbl_bypass` = 1, the sample is p[10:1] when p[11] = 0 and the bitwise inverse of p[10:1] when p[11] = 1.
- R6: With `sq_div2` = 0, `clk_out` equals bit 11 of the lookup phase, with the same latency as the sample.
- R7: With `sq_div2` = 1, `clk_out` is a divided copy that toggles once for each rising edge of lookup-phase bit 11.
- R8: While `sleep` = 1 the sample word holds its value, and the accumulator and `clk_out` keep running.
- R9: A synchronous `rst` clears the accumulator and all four stored words to zero. The sample goes to 512, and `clk_out` goes to 0.
- R10: A sample appears two clocks after its accumulator value. `wr_sel` codes are 0 for frequency word 0, 1 for frequency word 1, 2 for phase word 0 (from `wr_data[11:0]`) and 3 for phase word 1. A written word is used from the edge after the write.
- R11: A register write never changes the accumulator value. Only the step size changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 28 | Write data |
| freq_sel | input | 1 | Frequency word select |
| phase_sel | input | 1 | Phase word select |
| tbl_bypass | input | 1 | 1 selects the triangle ramp instead of the sine |
| sq_div2 | input | 1 | 1 selects the divided square on `clk_out` |
| sleep | input | 1 | Freezes the sample word |
| sample | output | 10 | Offset-binary output sample |
| clk_out | output | 1 | Square-wave clock output |

## Verification
Several properties are checked on every cycle:
- the sample held during sleep;
- the sine range never reaching zero;
- the triangle fold of the registered phase;
- the tracking of the phase MSB by `clk_out`;
- the toggling of the divided square on MSB rising edges.

Other behaviour only the bench scenarios can show, because it needs the stored words and the history of the accumulator:
- the selection of frequency and phase words;
- modulo wraparound of the accumulator;
- the exact sine amplitudes;
- the one-edge delay of register writes;
- the reset values.

// File: rtl/dds_wave_core.sv
module dds_wave_core #(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12,
  parameter int OUT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [ACC_W-1:0] wr_data,
  input  logic             freq_sel,
  input  logic             phase_sel,
  input  logic             tbl_bypass,
  input  logic             sq_div2,
  input  logic             sleep,
  output logic [OUT_W-1:0] sample,
  output logic             clk_out
);

  localparam int QB  = PH_W - 2;
  localparam int QN  = (1 << QB) + 1;
  localparam int AMP = (1 << (OUT_W - 1)) - 1;
  localparam logic [OUT_W-1:0] MID = OUT_W'(1 << (OUT_W - 1));
  localparam real PI = 3.14159265358979323846;

  logic [ACC_W-1:0] freq0, freq1, acc;
  logic [PH_W-1:0]  phase0, phase1, ph_q;
  logic             msb_q, tog_q;

  logic [OUT_W-2:0] qtab [QN];

  for (genvar i = 0; i < QN; i++) begin : g_qtab
    localparam int V = int'($floor(AMP * $sin(PI * i / (2.0 * (QN - 1))) + 0.5));
    assign qtab[i] = (OUT_W-1)'(V);
  end

  wire [ACC_W-1:0] step   = freq_sel  ? freq1  : freq0;
  wire [PH_W-1:0]  offset = phase_sel ? phase1 : phase0;
  wire [PH_W-1:0]  ph_d   = acc[ACC_W-1 -: PH_W] + offset;

  wire [1:0]       quad   = ph_q[PH_W-1 -: 2];
  wire [QB-1:0]    idx    = ph_q[QB-1:0];
  wire [QB:0]      fidx   = quad[0] ? ((QB+1)'(1 << QB) - {1'b0, idx}) : {1'b0, idx};
  wire [OUT_W-2:0] mag    = qtab[fidx];
  wire [OUT_W-1:0] sine   = quad[1] ? (MID - {1'b0, mag}) : (MID + {1'b0, mag});
  wire [OUT_W-1:0] ramp   = ph_q[PH_W-1] ? ~ph_q[PH_W-2 -: OUT_W] : ph_q[PH_W-2 -: OUT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      freq0  <= '0;
      freq1  <= '0;
      phase0 <= '0;
      phase1 <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: freq0  <= wr_data;
        2'd1: freq1  <= wr_data;
        2'd2: phase0 <= wr_data[PH_W-1:0];
        default: phase1 <= wr_data[PH_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      ph_q   <= '0;
      sample <= MID;
      msb_q  <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      acc   <= acc + step;
      ph_q  <= ph_d;
      msb_q <= ph_q[PH_W-1];
      tog_q <= tog_q ^ (ph_q[PH_W-1] & ~msb_q);
      if (!sleep) sample <= tbl_bypass ? ramp : sine;
    end
  end

  assign clk_out = sq_div2 ? tog_q : msb_q;

endmodule

// File: rtl/dds_wave_core_chk.sv
module dds_wave_core_chk #(
  parameter int PH_W  = 12,
  parameter int OUT_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             sleep,
  input logic             tbl_bypass,
  input logic             sq_div2,
  input logic [OUT_W-1:0] sample,
  input logic             clk_out,
  input logic [PH_W-1:0]  ph_q,
  input logic             msb_q
);

  assert_sleep_hold_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(sleep) && !$past(rst)) |-> $stable(sample));

  assert_sine_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(tbl_bypass) && !$past(sleep) && !$past(rst)) |-> (sample != '0));

  assert_ramp_fold_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(tbl_bypass) && !$past(sleep) && !$past(rst)) |->
      (sample == ($past(ph_q[PH_W-1]) ? ~$past(ph_q[PH_W-2 -: OUT_W]) : $past(ph_q[PH_W-2 -: OUT_W]))));

  assert_clk_msb_R6: assert property (@(posedge clk) disable iff (rst)
    (!sq_div2 && !$past(rst)) |-> (clk_out == $past(ph_q[PH_W-1])));

  assert_div_toggle_R7: assert property (@(posedge clk) disable iff (rst)
    (sq_div2 && $past(sq_div2) && !$past(rst)) |->
      ((clk_out != $past(clk_out)) == ($past(ph_q[PH_W-1]) && !$past(msb_q))));

endmodule

bind dds_wave_core dds_wave_core_chk #(.PH_W(PH_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .sleep(sleep), .tbl_bypass(tbl_bypass), .sq_div2(sq_div2),
  .sample(sample), .clk_out(clk_out), .ph_q(ph_q), .msb_q(msb_q)
);

// File: tb/test_dds_wave_core.sv
`timescale 1ns/1ps
module test_dds_wave_core;
  logic clk = 0, rst = 1, wr_en = 0, freq_sel = 0, phase_sel = 0;
  logic tbl_bypass = 0, sq_div2 = 0, sleep = 0;
  logic [1:0] wr_sel = 0;
  logic [27:0] wr_data = 0;
  logic [9:0] sample;
  logic clk_out;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R9";

  dds_wave_core i_dds_wave_core (.*);

  always #2 clk = ~clk;

  longint m_acc, m_f0, m_f1;
  int m_p0, m_p1, m_ph, m_smp;
  bit m_msb, m_tog, m_sine;

  function automatic int sine_ref(int p);
    real v = 511.0 * $sin(2.0 * 3.14159265358979 * p / 4096.0);
    return 512 + int'($floor(v + 0.5));
  endfunction

  function automatic int tri_ref(int p);
    int m = (p >> 1) & 1023;
    return (p >= 2048) ? (1023 - m) : m;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_acc = 0; m_f0 = 0; m_f1 = 0; m_p0 = 0; m_p1 = 0;
      m_ph = 0; m_smp = 512; m_msb = 0; m_tog = 0; m_sine = 0;
    end else begin
      if (!sleep) begin
        m_smp  = tbl_bypass ? tri_ref(m_ph) : sine_ref(m_ph);
        m_sine = !tbl_bypass;
      end
      m_tog = m_tog ^ ((m_ph >= 2048) && !m_msb);
      m_msb = (m_ph >= 2048);
      m_ph  = int'(((m_acc >> 16) + (phase_sel ? m_p1 : m_p0)) % 4096);
      m_acc = (m_acc + (freq_sel ? m_f1 : m_f0)) % (64'd1 << 28);
      if (wr_en)
        case (wr_sel)
          2'd0: m_f0 = wr_data;
          2'd1: m_f1 = wr_data;
          2'd2: m_p0 = wr_data[11:0];
          default: m_p1 = wr_data[11:0];
        endcase
    end
    #1;
    if (!done) begin
      string st = sleep ? "R8" : (tbl_bypass ? "R5" : "R4");
      int d = int'(sample) - m_smp;
      checks++;
      if ((m_sine && (d > 1 || d < -1)) || (!m_sine && d != 0)) begin
        errors++;
        $display("FAIL %s %s sample got %0d expected %0d", st, tag, sample, m_smp);
      end
      checks++;
      if (clk_out !== (sq_div2 ? m_tog : m_msb)) begin
        errors++;
        $display("FAIL %s %s clk_out got %0b expected %0b", sq_div2 ? "R7" : "R6", tag,
                 clk_out, sq_div2 ? m_tog : m_msb);
      end
    end
  end

  task automatic wr(input logic [1:0] s, input logic [27:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    run(3);
    rst = 0;
    @(negedge clk);
    tag = "R9";
    checks++;
    if (sample !== 10'd512 || clk_out !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset got %0d/%0b expected 512/0", sample, clk_out);
    end
    tag = "R1";
    wr(2'd0, 28'h0123457);
    run(300);
    tag = "R2";
    wr(2'd1, 28'h0400000);
    freq_sel = 1;
    run(200);
    tag = "R3";
    wr(2'd3, 28'hFFFF400);
    phase_sel = 1;
    run(100);
    wr(2'd2, 28'h0000A5C);
    phase_sel = 0;
    run(100);
    tag = "R5";
    tbl_bypass = 1;
    run(200);
    tag = "R7";
    sq_div2 = 1;
    run(300);
    tag = "R8";
    sleep = 1;
    run(150);
    sleep = 0;
    tbl_bypass = 0;
    run(100);
    tag = "R11";
    wr(2'd1, 28'h0010000);
    wr(2'd1, 28'h1000000);
    run(100);
    tag = "R1";
    wr(2'd1, 28'hFFF0000);
    run(200);
    tag = "R10";
    repeat (20) begin
      @(negedge clk);
      freq_sel = ~freq_sel;
      phase_sel = ~phase_sel;
    end
    sq_div2 = 0;
    run(50);
    tag = "R9";
    rst = 1;
    run(2);
    rst = 0;
    run(100);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule